// File: doc/BRIEF.md
# 32-Pin General-Purpose I/O Bank

This block is one bank of general-purpose I/O pins behind a small register port. Software sets each pin's direction in an active-low direction mask, where a 1 keeps the pin as an input. It drives output levels through an output latch and reads pad levels from a synchronized sample register. The latch can be loaded in three ways. A direct write replaces every bit. A write to the set alias raises only the bits written as 1. A write to the clear alias lowers only the bits written as 1. With the two aliases, several agents can change separate pins without a read-modify-write race.

Pad inputs pass through a chain of synchronizer flops before software can see them. A fixed identification word sits at offset zero. The bus side has no handshake. Writes take effect at the clock edge where write enable is high. Read data is registered, so it shows the addressed register one clock after the address is presented.

Top module: `gpio_bank`

## Requirements
- R1: While reset is high, and in the first clock after it, the direction mask is all ones, the output latch is all zeros, `pad_oe` is 0 and `bus_rdata` is 0.
- R2: Byte offset 0x134 holds the direction mask. It can be written and read back. A bit of 1 makes that pin an input and a bit of 0 makes it a driven output.
- R3: Byte offset 0x13C holds the output latch. A write replaces all bits and a read returns them. The latch holds its value in any cycle without a latch-changing write.
- R4: A write to byte offset 0x190 clears each latch bit written as 1 and leaves bits written as 0 unchanged.
- R5: A write to byte offset 0x194 sets each latch bit written as 1 and leaves bits written as 0 unchanged.
- R6: `pad_oe[p]` is the inverse of direction bit p. `pad_o[p]` carries latch bit p.
- R7: A read of byte offset 0x138 returns the pad levels after a two-flop synchronizer. A pad change made before clock edge k appears in the sampled value from edge k+1. Writes to this offset are ignored.
- R8: A read of byte offset 0x000 returns the identification word 0x50600801. Writes to it are ignored.
- R9: Reads of the two alias offsets, and of every other unmapped offset, return 0.
- R10: `bus_rdata` shows the register selected by `bus_addr` as it stood before the edge that captures the read, one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_i | input | 32 | Pad input levels (asynchronous) |
| pad_o | output | 32 | Output latch driven toward the pads |
| pad_oe | output | 32 | Per-pin output enable, 1 drives the pad |

## Verification
The bench builds the bank with its default parameters: 32 pins, a 12-bit byte address and two synchronizer stages. The full width lets the aliases be checked on patterns that touch both halves of the word. The two stages make the pad-to-register delay short enough to check exactly on every clock. Randomized pad levels and random accesses to mapped, alias and unmapped offsets reach mixes of direction and latch values, including writes to read-only offsets, that the directed phase does not cover.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [11:0] OFF_IDENT = 12'h000;
  localparam logic [11:0] OFF_DIR   = 12'h134;
  localparam logic [11:0] OFF_DIN   = 12'h138;
  localparam logic [11:0] OFF_DOUT  = 12'h13C;
  localparam logic [11:0] OFF_CLR   = 12'h190;
  localparam logic [11:0] OFF_SET   = 12'h194;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IDENT,
    SEL_DIR,
    SEL_DIN,
    SEL_DOUT
  } rd_sel_e;

  function automatic rd_sel_e decode_read(input logic [11:0] a);
    case (a)
      OFF_IDENT: return SEL_IDENT;
      OFF_DIR:   return SEL_DIR;
      OFF_DIN:   return SEL_DIN;
      OFF_DOUT:  return SEL_DOUT;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_dir,
  input  logic         wr_dout,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dout_q
);
  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '1;
    else if (wr_dir) dir_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          dout_q <= '0;
    else if (wr_dout) dout_q <= wdata;
    else if (wr_set)  dout_q <= dout_q | wdata;
    else if (wr_clr)  dout_q <= dout_q & ~wdata;
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_bank_pkg::*;
#(
  parameter int          W     = 32,
  parameter logic [31:0] IDENT = 32'h5060_0801
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [11:0]  addr,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] din_q,
  input  logic [W-1:0] dout_q,
  output logic [W-1:0] rdata
);
  rd_sel_e      sel;
  logic [W-1:0] nxt;

  always_comb begin
    sel = decode_read(addr);
    case (sel)
      SEL_IDENT: nxt = W'(IDENT);
      SEL_DIR:   nxt = dir_q;
      SEL_DIN:   nxt = din_q;
      SEL_DOUT:  nxt = dout_q;
      default:   nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int          PINS        = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] IDENT       = 32'h5060_0801
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [11:0]     bus_addr,
  input  logic            bus_we,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_i,
  output logic [PINS-1:0] pad_o,
  output logic [PINS-1:0] pad_oe
);
  logic [PINS-1:0] dir_q, dout_q, din_q;
  logic wr_dir, wr_dout, wr_set, wr_clr;

  assign wr_dir  = bus_we && (bus_addr == OFF_DIR);
  assign wr_dout = bus_we && (bus_addr == OFF_DOUT);
  assign wr_set  = bus_we && (bus_addr == OFF_SET);
  assign wr_clr  = bus_we && (bus_addr == OFF_CLR);

  gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_i), .q(din_q)
  );

  gpio_out_latch #(.W(PINS)) u_latch (
    .clk(clk), .rst(rst),
    .wr_dir(wr_dir), .wr_dout(wr_dout), .wr_set(wr_set), .wr_clr(wr_clr),
    .wdata(bus_wdata), .dir_q(dir_q), .dout_q(dout_q)
  );

  gpio_read_mux #(.W(PINS), .IDENT(IDENT)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr),
    .dir_q(dir_q), .din_q(din_q), .dout_q(dout_q), .rdata(bus_rdata)
  );

  assign pad_o  = dout_q;
  assign pad_oe = ~dir_q;
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int          PINS  = 32,
  parameter logic [31:0] IDENT = 32'h5060_0801
) (
  input logic            clk,
  input logic            rst,
  input logic [11:0]     bus_addr,
  input logic            bus_we,
  input logic [PINS-1:0] bus_wdata,
  input logic [PINS-1:0] bus_rdata,
  input logic [PINS-1:0] pad_o,
  input logic [PINS-1:0] pad_oe
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_o == '0 && bus_rdata == '0)); // R1

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_DIR) |=> (pad_oe == ~$past(bus_wdata))); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(pad_o)); // R3

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_CLR) |=> ((pad_o & $past(bus_wdata)) == '0)); // R4

  AST_CLR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_CLR) |=>
      ((pad_o & ~$past(bus_wdata)) == ($past(pad_o) & ~$past(bus_wdata)))); // R4

  AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_SET) |=> ((pad_o & $past(bus_wdata)) == $past(bus_wdata))); // R5

  AST_SET_KEEP: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_SET) |=>
      ((pad_o & ~$past(bus_wdata)) == ($past(pad_o) & ~$past(bus_wdata)))); // R5

  AST_IDENT_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFF_IDENT) |=> (bus_rdata == PINS'(IDENT))); // R8

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFF_SET || bus_addr == OFF_CLR) |=> (bus_rdata == '0)); // R9
endmodule

bind gpio_bank gpio_bank_checker #(.PINS(PINS), .IDENT(IDENT)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_o(pad_o), .pad_oe(pad_oe)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam logic [31:0] IDENT = 32'h5060_0801;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_i = '0;
  logic [31:0] pad_o, pad_oe;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  // Behavioural reference state
  logic [31:0] m_dir, m_dout, m_rd;
  logic [31:0] m_pipe [$];

  initial begin
    m_dir = '1; m_dout = '0; m_rd = '0;
    m_pipe = '{32'h0, 32'h0};
  end

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_dir = '1; m_dout = '0; m_rd = '0;
      m_pipe = '{32'h0, 32'h0};
    end else begin
      case (bus_addr)
        12'h000: m_rd = IDENT;
        12'h134: m_rd = m_dir;
        12'h138: m_rd = m_pipe[1];
        12'h13C: m_rd = m_dout;
        default: m_rd = '0;
      endcase
      if (bus_we) begin
        case (bus_addr)
          12'h134: m_dir = bus_wdata;
          12'h13C: m_dout = bus_wdata;
          12'h194: m_dout = m_dout | bus_wdata;
          12'h190: m_dout = m_dout & ~bus_wdata;
          default: ;
        endcase
      end
      void'(m_pipe.pop_back());
      m_pipe.push_front(pad_i);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic string rd_tag(input logic [11:0] a);
    case (a)
      12'h000: return "R8 ident/R10";
      12'h134: return "R2 dir/R10";
      12'h138: return "R7 din/R10";
      12'h13C: return "R3 dout/R10";
      default: return "R9 unmapped";
    endcase
  endfunction

  logic [11:0] last_addr = '0;

  // One bus cycle: compare at the falling edge, then drive the next inputs
  task automatic cycle(input logic [11:0] a, input logic we, input logic [31:0] d);
    @(negedge clk);
    check(rd_tag(last_addr), bus_rdata, m_rd);
    check("R6 pad_o", pad_o, m_dout);
    check("R6 pad_oe", pad_oe, ~m_dir);
    bus_addr = a; bus_we = we; bus_wdata = d; last_addr = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_o", pad_o, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rst = 1'b0;

    cycle(12'h000, 0, 0);
    cycle(12'h134, 0, 0);
    cycle(12'h134, 1, 32'hFFFF_0000);
    cycle(12'h134, 0, 0);
    cycle(12'h13C, 1, 32'hA5A5_A5A5);
    cycle(12'h13C, 0, 0);
    cycle(12'h194, 1, 32'h0F0F_0000);
    cycle(12'h13C, 0, 0);
    cycle(12'h190, 1, 32'h0000_00FF);
    cycle(12'h13C, 0, 0);
    cycle(12'h194, 1, 32'h0);
    cycle(12'h190, 1, 32'h0);
    cycle(12'h13C, 0, 0);
    cycle(12'h138, 1, 32'hDEAD_BEEF);
    cycle(12'h000, 1, 32'h1234_5678);
    cycle(12'h000, 0, 0);
    cycle(12'h190, 0, 0);
    cycle(12'h194, 0, 0);
    cycle(12'h004, 0, 0);
    cycle(12'h13A, 0, 0);
    @(negedge clk);
    check("R6 pad_o directed", pad_o, 32'hAFAF_A500);
    check("R2 pad_oe directed", pad_oe, 32'h0000_FFFF);

    // R7: pad step observed through the synchronizer
    pad_i = 32'h8000_0001;
    for (int i = 0; i < 5; i++) cycle(12'h138, 0, 0);

    // Randomized mix
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      case ($urandom_range(0, 8))
        0: a = 12'h000; 1: a = 12'h134; 2: a = 12'h138; 3: a = 12'h13C;
        4: a = 12'h190; 5: a = 12'h194; 6: a = 12'h190; 7: a = 12'h194;
        default: a = 12'($urandom_range(0, 4095));
      endcase
      if ($urandom_range(0, 3) == 0) pad_i = $urandom;
      cycle(a, 1'($urandom_range(0, 1)), $urandom);
    end

    // Mid-run reset
    cycle(12'h13C, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    bus_addr = 12'h134; bus_we = 0; last_addr = 12'h134;
    check("R1 pad_oe after reset", pad_oe, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    cycle(12'h13C, 0, 0);
    cycle(12'h000, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule